// File: doc/BRIEF.md
# Dual-Lane Two-Point Butterfly Stage

This block is the last radix-2 stage of a pipelined transform that moves two complex samples per clock. On every clock with the enable high it takes two packed complex words, called lane A and lane B. It returns their sum on the sum lane and their difference (A minus B) on the difference lane. Both parts of each result are one bit wider than the inputs, so no result can overflow.

A frame marker enters next to the data and moves through a delay line whose length equals the data latency. The output marker therefore flags the first result of each frame. Downstream logic treats the outputs as meaningful only after the first marker has come out. A synchronous reset empties the marker line, and no output marker appears again until a new input marker is accepted. With the default configuration the latency is two enabled cycles, made of an input register and an output register. A parameter can remove the input register, which gives one enabled cycle.

Top module: `dual_lane_bfly_stage`

## Requirements
- R1: Each input lane is 32 bits wide. Bits 31:16 hold the signed real part and bits 15:0 hold the signed imaginary part, both in two's complement.
- R2: The sum lane carries A+B, with real and imaginary parts computed separately. Bits 33:17 hold the 17-bit signed real part and bits 16:0 hold the 17-bit signed imaginary part.
- R3: The difference lane carries A−B, with real and imaginary parts computed separately, in the same 17-bit field layout as R2.
- R4: Operands are sign-extended before the add and the subtract, so every result is exact for all input values, including −32768 and 32767.
- R5: With the default parameters, the results for the inputs accepted on an enabled edge appear after the second enabled edge, counting that one. out_sync is high on exactly that output cycle when in_sync was high with those inputs.
- R6: While ce is low, every pipeline register holds its value, including the marker line. Data and in_sync presented in those cycles have no effect.
- R7: An active-high synchronous reset clears the outputs to zero and empties the marker line. A marker already inside the line when reset is applied never reaches out_sync.
- R8: out_sync is never high unless a marker was accepted with in_sync.
- R9: An accepted input marker reaches out_sync within 20 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for every pipeline register |
| in_sync | input | 1 | Frame marker that goes with the current input pair |
| in_a | input | 32 | Lane A complex sample {re, im} |
| in_b | input | 32 | Lane B complex sample {re, im} |
| out_sum | output | 34 | A+B as {re, im}, 17 bits each |
| out_dif | output | 34 | A−B as {re, im}, 17 bits each |
| out_sync | output | 1 | Marks the first result of a frame |

## Verification
The bound checker tests a number of properties on every cycle. Outputs and the marker must hold while ce is low. Reset must leave out_sync low. A rising out_sync must follow an enabled edge. The sum and the difference must share the least significant bit of each part, which must always hold because their sum is even. Only the bench scenarios can show that the values are numerically exact and that the marker lines up with the right result. Those scenarios are a sweep over extreme and mid-range operand pairs, long pseudo-random streams, enable gaps with in_sync pulsed while ce is low, and a reset applied while a marker is still in flight.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
   parameter int unsigned BFLY_DEF_W = 16;

   // latency in enabled cycles: optional input register + output register
   function automatic int unsigned bfly_latency(input bit reg_in);
      return reg_in ? 2 : 1;
   endfunction
endpackage

// File: rtl/bfly_sync_line.sv
module bfly_sync_line #(
   parameter int unsigned DEPTH = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic d,
   output logic q
);
   logic [DEPTH-1:0] line_q;

   generate
      if (DEPTH == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst)     line_q <= '0;
            else if (ce) line_q <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (rst)     line_q <= '0;
            else if (ce) line_q <= {line_q[DEPTH-2:0], d};
         end
      end
   endgenerate

   assign q = line_q[DEPTH-1];
endmodule

// File: rtl/bfly_in_stage.sv
module bfly_in_stage #(
   parameter int unsigned W   = 32,
   parameter bit          REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (REG) begin : g_reg
         logic [W-1:0] q_r;
         always_ff @(posedge clk) begin
            if (rst)     q_r <= '0;
            else if (ce) q_r <= d;
         end
         assign q = q_r;
      end else begin : g_pass
         logic unused_ok;
         assign unused_ok = clk ^ rst ^ ce;
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/bfly_lane_addsub.sv
module bfly_lane_addsub #(
   parameter int unsigned IW = 16,
   localparam int unsigned OW = IW + 1
) (
   input  logic [2*IW-1:0] a,
   input  logic [2*IW-1:0] b,
   output logic [2*OW-1:0] sum,
   output logic [2*OW-1:0] dif
);
   logic signed [OW-1:0] a_re, a_im, b_re, b_im;

   always_comb begin
      a_re = {a[2*IW-1], a[2*IW-1:IW]};
      a_im = {a[IW-1],   a[IW-1:0]};
      b_re = {b[2*IW-1], b[2*IW-1:IW]};
      b_im = {b[IW-1],   b[IW-1:0]};
      sum  = {a_re + b_re, a_im + b_im};
      dif  = {a_re - b_re, a_im - b_im};
   end
endmodule

// File: rtl/dual_lane_bfly_stage.sv
module dual_lane_bfly_stage #(
   parameter int unsigned IN_W   = bfly_pkg::BFLY_DEF_W,
   parameter bit          REG_IN = 1'b1,
   localparam int unsigned OUT_W = IN_W + 1,
   localparam int unsigned LAT   = bfly_pkg::bfly_latency(REG_IN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  logic              in_sync,
   input  logic [2*IN_W-1:0] in_a,
   input  logic [2*IN_W-1:0] in_b,
   output logic [2*OUT_W-1:0] out_sum,
   output logic [2*OUT_W-1:0] out_dif,
   output logic              out_sync
);
   generate
      if (IN_W < 2) begin : g_bad_w
         $error("IN_W must be at least 2");
      end
      if (LAT > 20) begin : g_bad_lat
         $error("latency exceeds the marker window");
      end
   endgenerate

   logic [2*IN_W-1:0]  a_s, b_s;
   logic [2*OUT_W-1:0] sum_c, dif_c;
   logic [2*OUT_W-1:0] sum_q, dif_q;

   bfly_in_stage #(.W(2*IN_W), .REG(REG_IN)) u_in_a (
      .clk(clk), .rst(rst), .ce(ce), .d(in_a), .q(a_s));
   bfly_in_stage #(.W(2*IN_W), .REG(REG_IN)) u_in_b (
      .clk(clk), .rst(rst), .ce(ce), .d(in_b), .q(b_s));

   bfly_lane_addsub #(.IW(IN_W)) u_math (
      .a(a_s), .b(b_s), .sum(sum_c), .dif(dif_c));

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q <= '0;
         dif_q <= '0;
      end else if (ce) begin
         sum_q <= sum_c;
         dif_q <= dif_c;
      end
   end

   bfly_sync_line #(.DEPTH(LAT)) u_sync (
      .clk(clk), .rst(rst), .ce(ce), .d(in_sync), .q(out_sync));

   assign out_sum = sum_q;
   assign out_dif = dif_q;
endmodule

// File: rtl/bfly_stage_chk.sv
module bfly_stage_chk #(
   parameter int unsigned OUT_W = 17
) (
   input logic               clk,
   input logic               rst,
   input logic               ce,
   input logic [2*OUT_W-1:0] out_sum,
   input logic [2*OUT_W-1:0] out_dif,
   input logic               out_sync
);
   // R6
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !ce |=> ($stable(out_sum) && $stable(out_dif) && $stable(out_sync)));

   // R7
   reset_clears_sync_chk: assert property (@(posedge clk)
      rst |=> !out_sync);

   // R8
   sync_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(out_sync) |-> $past(ce));

   // R2
   re_parity_chk: assert property (@(posedge clk) disable iff (rst)
      out_sum[OUT_W] == out_dif[OUT_W]);

   // R3
   im_parity_chk: assert property (@(posedge clk) disable iff (rst)
      out_sum[0] == out_dif[0]);
endmodule

bind dual_lane_bfly_stage bfly_stage_chk #(.OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst(rst), .ce(ce), .out_sum(out_sum),
   .out_dif(out_dif), .out_sync(out_sync));

// File: tb/tb_dual_lane_bfly_stage.sv
module tb_dual_lane_bfly_stage;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ce = 1'b0;
   logic        in_sync = 1'b0;
   logic [31:0] in_a = '0, in_b = '0;
   logic [33:0] out_sum, out_dif;
   logic        out_sync;

   int total = 0;
   int bad = 0;

   // expected history: [1] newest accepted, [2] the one now at the outputs
   logic [33:0] hs1 = '0, hs2 = '0, hd1 = '0, hd2 = '0;
   logic        hy1 = 1'b0, hy2 = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dual_lane_bfly_stage dut (
      .clk(clk), .rst(rst), .ce(ce), .in_sync(in_sync), .in_a(in_a),
      .in_b(in_b), .out_sum(out_sum), .out_dif(out_dif), .out_sync(out_sync));

   function automatic logic [33:0] ref_op(input logic [31:0] a, input logic [31:0] b,
                                          input bit sub);
      int ar, ai, br, bi, rr, ri;
      ar = int'($signed(a[31:16])); ai = int'($signed(a[15:0]));
      br = int'($signed(b[31:16])); bi = int'($signed(b[15:0]));
      rr = sub ? ar - br : ar + br;
      ri = sub ? ai - bi : ai + bi;
      return {rr[16:0], ri[16:0]};
   endfunction

   task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input logic e, input logic r, input string req);
      @(negedge clk);
      in_a = a; in_b = b; in_sync = s; ce = e; rst = r;
      @(posedge clk);
      if (r) begin
         hs1 = '0; hs2 = '0; hd1 = '0; hd2 = '0; hy1 = 1'b0; hy2 = 1'b0;
      end else if (e) begin
         hs2 = hs1; hd2 = hd1; hy2 = hy1;
         hs1 = ref_op(a, b, 1'b0); hd1 = ref_op(a, b, 1'b1); hy1 = s;
      end
      #2;
      check({req, "/R2"}, out_sum, hs2);
      check({req, "/R3"}, out_dif, hd2);
      check({req, "/R5 sync"}, {33'd0, out_sync}, {33'd0, hy2});
   endtask

   initial begin
      #(CLK_P * 100000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] v [8];
      logic [31:0] lf;
      int since;
      v[0] = 16'h8000; v[1] = 16'h8001; v[2] = 16'hC000; v[3] = 16'hFFFF;
      v[4] = 16'h0000; v[5] = 16'h0001; v[6] = 16'h3FFF; v[7] = 16'h7FFF;
      lf = 32'h1ACE_B00C;

      // reset state, R7
      step('0, '0, 1'b0, 1'b0, 1'b1, "R7 reset");
      step('0, '0, 1'b0, 1'b0, 1'b1, "R7 reset");
      check("R7 out_sync low", {33'd0, out_sync}, 34'd0);

      // no marker yet: out_sync stays low, R8
      for (int k = 0; k < 10; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         step(lf, ~lf, 1'b0, 1'b1, 1'b0, "R8 no marker");
      end

      // R1/R4 sweep of extreme operands, marker on first item
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            step({v[i], v[(j + 3) % 8]}, {v[j], v[(i + 5) % 8]},
                 (i == 0 && j == 0), 1'b1, 1'b0, "R1 R4 sweep");
         end
      end

      // R9: marker out within 20 enabled cycles
      step(32'h0001_0002, 32'h0003_0004, 1'b1, 1'b1, 1'b0, "R9 mark");
      since = 0;
      while (!out_sync && since < 25) begin
         step(32'h0, 32'h0, 1'b0, 1'b1, 1'b0, "R9 wait");
         since++;
      end
      check("R9 marker window", 34'(since <= 20), 34'd1);

      // R6: enable gaps with data and marker applied while idle
      step(32'h1234_8765, 32'h7FFF_8000, 1'b1, 1'b1, 1'b0, "R6 pre");
      for (int k = 0; k < 6; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         step(lf, lf ^ 32'h5A5A_A5A5, 1'b1, 1'b0, 1'b0, "R6 idle");
      end
      for (int k = 0; k < 3; k++) step('0, '0, 1'b0, 1'b1, 1'b0, "R6 drain");

      // R7: reset with a marker in flight
      step(32'h0100_0100, 32'h0200_0200, 1'b1, 1'b1, 1'b0, "R7 inflight");
      step('0, '0, 1'b0, 1'b1, 1'b1, "R7 reset mid");
      for (int k = 0; k < 4; k++) begin
         step('0, '0, 1'b0, 1'b1, 1'b0, "R7 after");
         check("R7 marker flushed", {33'd0, out_sync}, 34'd0);
      end

      // long pseudo-random stream with periodic markers and gaps
      for (int k = 0; k < 2000; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         step(lf, {lf[7:0], lf[31:8]}, ((k % 64) == 0), (lf[3:0] != 4'h0),
              1'b0, "R2 R3 R5 random");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule